// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a register-mapped timer with a parameterised number of independent down-counters. Each channel holds a control word, a software-loaded period value (the fixed count) and a running count that it decrements on the tick source picked by a 4-bit select code. A tick source is one of eight external enable inputs, a slow reference enable, or every clock. All tick sources reach the block as enable pulses that are already synchronous to its clock.

A channel either stops at zero or reloads from its fixed count and keeps running freely. An UPDATE bit lets a write to the fixed count take effect in the running counter at once. Elapsed time is the bitwise complement of the running count. When a channel's count steps from one to zero it raises a sticky interrupt flag. The flag is masked by a per-channel enable, and the block ORs the masked flags into one interrupt line.

Each writable register answers at three addresses: a plain write, a set alias that ORs the data in, and a clear alias that removes the written ones. Software can therefore change single bits without a read-modify-write. A global control word and a read-only version word complete the map.

Top module: `dntick_timer`

## Requirements
- R1: Every register decodes at three addresses. A write at its base address replaces the value. A write at base+4 ORs the data in. A write at base+8 clears the bits that are one in the data. A read at any of the three returns the register. The global control word at 0x000 is plain 32-bit storage.
- R2: The version word at 0x120 reads 0x0200_0000, with the major version 0x02 in bits [31:24]. Writes to it have no effect.
- R3: After reset, every control, fixed-count, running-count and global register reads zero, and `irq` is low.
- R4: A channel's running count drops by exactly one on each clock where its selected tick is high. The select code sits in control bits [3:0]. Codes 0x0–0x7 pick `tick_ext[code]`, 0xB picks `tick_slow`, 0xF ticks on every clock, and every other code never ticks. Ticks on inputs that are not selected leave the count unchanged.
- R5: The running count of channel n is read at 0x30+n*0x40 and cannot be written at any of its three addresses.
- R6: The interrupt flag in control bit 15 is set when the running count steps from 1 to 0. It stays set until software writes a 1 to bit 15 at the clear alias of the control word.
- R7: `irq` is high exactly when some channel has both its flag (bit 15) and its enable (bit 14) set.
- R8: With RELOAD (control bit 6) set, a tick that finds the running count at zero loads the fixed count. A fixed count of all ones makes the counter run through the full 32-bit range.
- R9: With RELOAD clear, the counter stays at zero. A write to the fixed count then restarts it from the written value, whatever the state of UPDATE.
- R10: With UPDATE (control bit 7) set, a fixed-count write loads the running count on the same clock edge. With UPDATE clear and the counter not stopped, the running count is not affected.
- R11: The control word of channel n lives at 0x20+n*0x40 and the fixed count at 0x40+n*0x40. Control bits other than [3:0], 6, 7, 14 and 15 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (12) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe; the write completes on the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_ext | input | NEXT (8) | External tick enables, picked by select codes 0x0–0x7 |
| tick_slow | input | 1 | Slow reference tick enable, picked by select code 0xB |
| irq | output | 1 | OR over the channels of flag AND enable |

## Verification
The counter is exercised on three tick sources in turn: a single external enable, the slow reference and the every-clock code. Pulses are placed on enables that are not selected, which separates a correct select decode from one that counts any tick. A fixed-count write is applied in three states: while the counter is stopped, while it runs with UPDATE clear, and while it runs with UPDATE set. These three cases separate the stop-restart path, the deferred path and the immediate-load path. A reloading channel is driven through zero to show a period of fixed+1 ticks, and it is loaded with all ones to show the full-range wrap. The interrupt line is checked against flags and enables spread over both channels and toggled through the aliases.

// File: rtl/dntick_pkg.sv
package dntick_pkg;

   localparam int DW         = 32;
   localparam int CH_STRIDE  = 'h40;
   localparam int CTRL_OFS   = 'h20;
   localparam int RUN_OFS    = 'h30;
   localparam int FIX_OFS    = 'h40;
   localparam int GCTRL_ADDR = 'h00;
   localparam int SET_OFS    = 4;
   localparam int CLR_OFS    = 8;

   localparam int B_RELOAD = 6;
   localparam int B_UPDATE = 7;
   localparam int B_IEN    = 14;
   localparam int B_IRQ    = 15;

   localparam logic [3:0]    SEL_SLOW   = 4'hB;
   localparam logic [3:0]    SEL_ALWAYS = 4'hF;
   localparam logic [DW-1:0] CTRL_MASK  = 32'h0000_C0CF;

   typedef enum logic [1:0] {
      AK_NONE,
      AK_WRITE,
      AK_SET,
      AK_CLR
   } acc_e;

   function automatic logic [DW-1:0] acc_apply(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] wd,
                                               input acc_e          op);
      logic [DW-1:0] res;
      case (op)
         AK_WRITE: res = wd;
         AK_SET:   res = cur | wd;
         AK_CLR:   res = cur & ~wd;
         default:  res = cur;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/dntick_win_dec.sv
module dntick_win_dec
   import dntick_pkg::*;
#(
   parameter int AW   = 12,
   parameter int BASE = 0
) (
   input  logic [AW-1:0] addr,
   output acc_e          op,
   output logic          hit
);
   localparam logic [AW-1:0] A_BASE = AW'(BASE);
   localparam logic [AW-1:0] A_SET  = AW'(BASE + SET_OFS);
   localparam logic [AW-1:0] A_CLR  = AW'(BASE + CLR_OFS);

   if (BASE % 4 != 0) begin : g_bad_align
      $error("dntick_win_dec: BASE must be word aligned");
   end
   if (BASE + CLR_OFS >= (1 << AW)) begin : g_bad_range
      $error("dntick_win_dec: window does not fit the address width");
   end

   always_comb begin
      if (addr == A_BASE)     op = AK_WRITE;
      else if (addr == A_SET) op = AK_SET;
      else if (addr == A_CLR) op = AK_CLR;
      else                    op = AK_NONE;
   end

   assign hit = (op != AK_NONE);
endmodule

// File: rtl/dntick_tick_sel.sv
module dntick_tick_sel
   import dntick_pkg::*;
#(
   parameter int NEXT = 8
) (
   input  logic [3:0]      sel,
   input  logic [NEXT-1:0] ext,
   input  logic            slow,
   output logic            tick
);
   localparam int NPAD = 8;

   logic [NPAD-1:0] ext_pad;

   if (NEXT < 1 || NEXT > NPAD) begin : g_bad_next
      $error("dntick_tick_sel: NEXT must lie in 1..8");
   end

   if (NEXT == NPAD) begin : g_full
      assign ext_pad = ext;
   end else begin : g_pad
      assign ext_pad = {{(NPAD - NEXT){1'b0}}, ext};
   end

   always_comb begin
      tick = 1'b0;
      if (!sel[3])                tick = ext_pad[sel[2:0]];
      else if (sel == SEL_SLOW)   tick = slow;
      else if (sel == SEL_ALWAYS) tick = 1'b1;
   end
endmodule

// File: rtl/dntick_chan.sv
module dntick_chan
   import dntick_pkg::*;
#(
   parameter int CW   = 32,
   parameter int NEXT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [DW-1:0]   wdata,
   input  acc_e            ctrl_op,
   input  acc_e            fix_op,
   input  logic [NEXT-1:0] tick_ext,
   input  logic            tick_slow,
   output logic [DW-1:0]   ctrl_q,
   output logic [CW-1:0]   fix_q,
   output logic [CW-1:0]   run_q,
   output logic            irq_req,
   output logic            tick_o,
   output logic            fix_wr_o
);
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] ZERO = '0;

   if (CW < 8 || CW > DW) begin : g_bad_cw
      $error("dntick_chan: CW must lie in 8..32");
   end

   logic          tick;
   logic          ctrl_wr;
   logic          fix_wr;
   logic          load_now;
   logic          irq_hit;
   logic [DW-1:0] ctrl_nxt;
   logic [DW-1:0] fix_full;
   logic [CW-1:0] fix_nxt;
   logic [CW-1:0] run_nxt;

   dntick_tick_sel #(.NEXT(NEXT)) u_tsel (
      .sel  (ctrl_q[3:0]),
      .ext  (tick_ext),
      .slow (tick_slow),
      .tick (tick)
   );

   assign ctrl_wr  = we && (ctrl_op != AK_NONE);
   assign fix_wr   = we && (fix_op != AK_NONE);
   assign fix_full = acc_apply(DW'(fix_q), wdata, fix_op);
   assign fix_nxt  = fix_wr ? fix_full[CW-1:0] : fix_q;

   // a stopped, non-reloading counter restarts on any fixed-count write
   assign load_now = fix_wr &&
                     (ctrl_q[B_UPDATE] || (run_q == ZERO && !ctrl_q[B_RELOAD]));
   assign irq_hit  = tick && !load_now && (run_q == ONE);

   always_comb begin
      ctrl_nxt = ctrl_q;
      if (ctrl_wr) ctrl_nxt = acc_apply(ctrl_q, wdata, ctrl_op) & CTRL_MASK;
      if (irq_hit) ctrl_nxt[B_IRQ] = 1'b1;
   end

   always_comb begin
      run_nxt = run_q;
      if (load_now) begin
         run_nxt = fix_nxt;
      end else if (tick) begin
         if (run_q != ZERO)          run_nxt = run_q - ONE;
         else if (ctrl_q[B_RELOAD])  run_nxt = fix_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         fix_q  <= '0;
         run_q  <= '0;
      end else begin
         ctrl_q <= ctrl_nxt;
         fix_q  <= fix_nxt;
         run_q  <= run_nxt;
      end
   end

   assign irq_req  = ctrl_q[B_IRQ] & ctrl_q[B_IEN];
   assign tick_o   = tick;
   assign fix_wr_o = fix_wr;
endmodule

// File: rtl/dntick_timer.sv
module dntick_timer
   import dntick_pkg::*;
#(
   parameter int         NCH       = 2,
   parameter int         CW        = 32,
   parameter int         NEXT      = 8,
   parameter int         AW        = 12,
   parameter int         VER_ADDR  = 'h120,
   parameter logic [7:0] VER_MAJOR = 8'h02
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic            bus_we,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NEXT-1:0] tick_ext,
   input  logic            tick_slow,
   output logic            irq
);
   localparam int            LAST_CH_END = FIX_OFS + (NCH - 1) * CH_STRIDE + CLR_OFS;
   localparam logic [DW-1:0] VER_WORD    = {VER_MAJOR, 24'h0};

   if (NCH < 1) begin : g_bad_nch
      $error("dntick_timer: NCH must be at least 1");
   end
   if (VER_ADDR <= LAST_CH_END) begin : g_bad_ver
      $error("dntick_timer: version word overlaps the channel windows");
   end

   logic [NCH-1:0][DW-1:0] ctrl_q;
   logic [NCH-1:0][CW-1:0] fix_q;
   logic [NCH-1:0][CW-1:0] run_q;
   logic [NCH-1:0]         irq_req;
   logic [NCH-1:0]         tick_v;
   logic [NCH-1:0]         fix_wr_v;
   logic [NCH-1:0]         ctrl_hit;
   logic [NCH-1:0]         fix_hit;
   logic [NCH-1:0]         run_hit;
   acc_e                   ctrl_op [NCH];
   acc_e                   fix_op  [NCH];
   acc_e                   run_op  [NCH];

   acc_e          g_op;
   logic          g_hit;
   acc_e          v_op;
   logic          v_hit;
   logic [DW-1:0] gctrl_q;

   dntick_win_dec #(.AW(AW), .BASE(GCTRL_ADDR)) u_gdec (
      .addr (bus_addr), .op (g_op), .hit (g_hit)
   );
   dntick_win_dec #(.AW(AW), .BASE(VER_ADDR)) u_vdec (
      .addr (bus_addr), .op (v_op), .hit (v_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               gctrl_q <= '0;
      else if (bus_we && g_hit) gctrl_q <= acc_apply(gctrl_q, bus_wdata, g_op);
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      dntick_win_dec #(.AW(AW), .BASE(CTRL_OFS + n * CH_STRIDE)) u_cdec (
         .addr (bus_addr), .op (ctrl_op[n]), .hit (ctrl_hit[n])
      );
      dntick_win_dec #(.AW(AW), .BASE(RUN_OFS + n * CH_STRIDE)) u_rdec (
         .addr (bus_addr), .op (run_op[n]), .hit (run_hit[n])
      );
      dntick_win_dec #(.AW(AW), .BASE(FIX_OFS + n * CH_STRIDE)) u_fdec (
         .addr (bus_addr), .op (fix_op[n]), .hit (fix_hit[n])
      );

      dntick_chan #(.CW(CW), .NEXT(NEXT)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .we        (bus_we),
         .wdata     (bus_wdata),
         .ctrl_op   (ctrl_op[n]),
         .fix_op    (fix_op[n]),
         .tick_ext  (tick_ext),
         .tick_slow (tick_slow),
         .ctrl_q    (ctrl_q[n]),
         .fix_q     (fix_q[n]),
         .run_q     (run_q[n]),
         .irq_req   (irq_req[n]),
         .tick_o    (tick_v[n]),
         .fix_wr_o  (fix_wr_v[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (g_hit) bus_rdata = bus_rdata | gctrl_q;
      if (v_hit) bus_rdata = bus_rdata | VER_WORD;
      for (int n = 0; n < NCH; n++) begin
         if (ctrl_hit[n]) bus_rdata = bus_rdata | ctrl_q[n];
         if (run_hit[n])  bus_rdata = bus_rdata | DW'(run_q[n]);
         if (fix_hit[n])  bus_rdata = bus_rdata | DW'(fix_q[n]);
      end
   end

   assign irq = |irq_req;
endmodule

// File: rtl/dntick_timer_chk.sv
module dntick_timer_chk #(
   parameter int NCH = 2,
   parameter int CW  = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCH-1:0][31:0]   ctrl_q,
   input logic [NCH-1:0][CW-1:0] fix_q,
   input logic [NCH-1:0][CW-1:0] run_q,
   input logic [NCH-1:0]         tick_v,
   input logic [NCH-1:0]         fix_wr_v
);
   for (genvar n = 0; n < NCH; n++) begin : g_c
      // R4
      dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_v[n] && !fix_wr_v[n] && run_q[n] != '0)
         |=> run_q[n] == $past(run_q[n]) - CW'(1));

      // R4
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick_v[n] && !fix_wr_v[n]) |=> $stable(run_q[n]));

      // R6
      flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_v[n] && !fix_wr_v[n] && run_q[n] == CW'(1)) |=> ctrl_q[n][15]);

      // R8
      reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_v[n] && !fix_wr_v[n] && run_q[n] == '0 && ctrl_q[n][6])
         |=> run_q[n] == $past(fix_q[n]));

      // R9
      stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_q[n] == '0 && !ctrl_q[n][6] && !fix_wr_v[n]) |=> run_q[n] == '0);

      // R10
      update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fix_wr_v[n] && ctrl_q[n][7]) |=> run_q[n] == fix_q[n]);
   end
endmodule

bind dntick_timer dntick_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_q   (ctrl_q),
   .fix_q    (fix_q),
   .run_q    (run_q),
   .tick_v   (tick_v),
   .fix_wr_v (fix_wr_v)
);

// File: tb/dntick_timer_test.sv
`timescale 1ns/1ps
module dntick_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic [7:0]  ext = '0;
   logic        slow = 1'b0;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [11:0] a;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  smp;

   always #2.5 clk = ~clk;

   dntick_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_we    (we),
      .bus_rdata (rdata),
      .tick_ext  (ext),
      .tick_slow (slow),
      .irq       (irq)
   );

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         @(smp);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = it.is_irq ? {31'b0, irq} : rdata;
            n_vec++;
            if (got !== it.exp) begin
               n_bad++;
               $display("FAIL %s addr=0x%03h got=0x%08h exp=0x%08h",
                        it.tag, it.a, got, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic chk(input logic [11:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; we = 1'b0;
      it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
      q.push_back(it);
      #1 -> smp;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.a = '0; it.exp = {31'b0, e}; it.tag = tag;
      q.push_back(it);
      #1 -> smp;
   endtask

   task automatic pulse_ext(input logic [7:0] m);
      @(negedge clk); ext = m;
      @(negedge clk); ext = '0;
   endtask

   task automatic pulse_slow();
      @(negedge clk); slow = 1'b1;
      @(negedge clk); slow = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got=hang exp=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset state
      chk(12'h020, 32'h0, "R3 ctrl0");
      chk(12'h030, 32'h0, "R3 run0");
      chk(12'h040, 32'h0, "R3 fix0");
      chk(12'h080, 32'h0, "R3 fix1");
      chk(12'h000, 32'h0, "R3 gctrl");
      chk_irq(1'b0, "R3 irq");

      // R2 version word, writes ignored
      chk(12'h120, 32'h0200_0000, "R2 version");
      wr(12'h120, 32'hFFFF_FFFF);
      chk(12'h120, 32'h0200_0000, "R2 version write ignored");

      // R1 alias semantics on the global word
      wr(12'h000, 32'h0000_F0F0);
      chk(12'h000, 32'h0000_F0F0, "R1 plain write");
      wr(12'h004, 32'h0F00_000F);
      chk(12'h008, 32'h0F00_F0FF, "R1 set alias");
      wr(12'h008, 32'h0000_00F0);
      chk(12'h004, 32'h0F00_F00F, "R1 clear alias");

      // R9 stopped channel restarts on a fixed write (UPDATE clear)
      wr(12'h020, 32'h0000_0000);
      wr(12'h040, 32'd5);
      chk(12'h030, 32'd5, "R9 restart from stop");
      chk(12'h040, 32'd5, "R11 fixed count readback");

      // R4 select decode with external enables
      pulse_ext(8'h02);
      chk(12'h030, 32'd5, "R4 unselected tick ignored");
      pulse_ext(8'h01);
      pulse_ext(8'h01);
      chk(12'h030, 32'd3, "R4 ext0 ticks");

      // R4 slow reference select
      wr(12'h020, 32'h0000_000B);
      pulse_slow();
      chk(12'h030, 32'd2, "R4 slow tick");
      pulse_ext(8'h01);
      chk(12'h030, 32'd2, "R4 ext0 ignored on slow select");

      // R6 flag on 1->0, R7 gating
      pulse_slow();
      pulse_slow();
      chk(12'h030, 32'd0, "R6 reached zero");
      chk(12'h020, 32'h0000_800B, "R6 flag set");
      chk_irq(1'b0, "R7 flag without enable");
      wr(12'h024, 32'h0000_4000);
      chk(12'h020, 32'h0000_C00B, "R1 set enable");
      chk_irq(1'b1, "R7 flag and enable");
      pulse_slow();
      chk(12'h030, 32'd0, "R9 stays at zero");
      wr(12'h028, 32'h0000_8000);
      chk(12'h020, 32'h0000_400B, "R6 flag acknowledged");
      chk_irq(1'b0, "R7 after acknowledge");

      // R5 running count is read-only
      wr(12'h030, 32'h0000_1234);
      wr(12'h034, 32'h0000_0040);
      chk(12'h030, 32'd0, "R5 run write ignored");

      // R10 deferred vs immediate fixed load
      wr(12'h040, 32'd10);
      chk(12'h030, 32'd10, "R9 restart second time");
      pulse_slow();
      pulse_slow();
      wr(12'h040, 32'd100);
      chk(12'h030, 32'd8, "R10 no load with UPDATE clear");
      chk(12'h040, 32'd100, "R10 fixed updated");
      wr(12'h024, 32'h0000_0080);
      wr(12'h040, 32'd50);
      chk(12'h030, 32'd50, "R10 immediate load");

      // R11 mask, R8 reload on channel 1 (ext1)
      wr(12'h060, 32'h0003_00C1);
      chk(12'h060, 32'h0000_00C1, "R11 reserved bits read zero");
      wr(12'h080, 32'd2);
      chk(12'h070, 32'd2, "R10 ch1 load");
      pulse_ext(8'h02);
      pulse_ext(8'h02);
      chk(12'h070, 32'd0, "R8 ch1 at zero");
      pulse_ext(8'h02);
      chk(12'h070, 32'd2, "R8 reload from fixed");
      chk(12'h060, 32'h0000_80C1, "R6 ch1 flag");
      chk(12'h030, 32'd50, "R4 ch0 untouched by ext1");

      // R8 full range
      wr(12'h080, 32'hFFFF_FFFF);
      chk(12'h070, 32'hFFFF_FFFF, "R8 all ones loaded");
      pulse_ext(8'h02);
      chk(12'h070, 32'hFFFF_FFFE, "R8 full range count");

      // R4 every-clock select
      wr(12'h040, 32'd1000);
      chk(12'h030, 32'd1000, "R10 ch0 load 1000");
      wr(12'h020, 32'h0000_000F);
      chk(12'h030, 32'd999, "R4 every clock first");
      chk(12'h030, 32'd998, "R4 every clock second");
      wr(12'h020, 32'h0000_0000);
      chk(12'h030, 32'd996, "R4 stop after select change");

      // R7 OR across channels
      chk_irq(1'b0, "R7 ch1 flag without enable");
      wr(12'h064, 32'h0000_4000);
      chk_irq(1'b1, "R7 ch1 raises irq");
      wr(12'h068, 32'h0000_8000);
      chk_irq(1'b0, "R7 ch1 acknowledged");

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule